// File: doc/BRIEF.md
# Windowed Event Counter Bank

This block holds a small set of wide event counters behind one narrow register port. Software first writes a counter number into a selector register. Later accesses to the condition, count, threshold and snapshot registers then act on that counter only. Each counter watches one line of a shared event vector, and the condition number stored for it picks the line. Condition number 0 never counts, so loading 0 stops a counter. A single run bit starts and stops the whole bank.

Software reads a counter that is still running in two steps. It first issues a snapshot command, which freezes the selected counter's full value into a shared snapshot register. It then reads that register in two 32-bit halves, so the value does not tear when the low half rolls over. Each counter also holds a threshold. When the count equals the threshold and the counter's interrupt enable is set, the counter's pending flag is set. Acknowledging a pending flag clears the counter's enable as well, so software has to re-arm the counter explicitly.

The register port is plain control access: a write takes effect on the clock edge where `reg_we` is high, and `reg_rdata` is a combinational function of `reg_addr` and the current state. The port has no back-pressure and no wait states. Register addresses (4 bits): 0 selector, 1 run/command, 2 condition, 3 count low, 4 count high, 5 snapshot low, 6 snapshot high, 7 threshold low, 8 threshold high, 9 interrupt enable, 10 interrupt pending, 11 build information.

Top module: `evc_bank`

## Requirements
- R1: After reset, every count, condition, threshold, enable and pending bit reads 0, the run bit (address 1, bit 0) reads 0, and `irq` is low.
- R2: Writing n to the selector (address 0) directs later accesses to addresses 2, 3, 4, 7 and 8 to counter n only. Other counters keep their values.
- R3: A write to address 1 sets the bank-wide run bit from bit 0 of the write data. While the run bit is 0, no counter advances.
- R4: A counter whose condition register (address 2, low log2(NUM_COND) bits) holds 0 never advances, whatever the event vector does.
- R5: While the run bit is set, a counter with condition c ≠ 0 advances by exactly one on each clock edge at which `evt_in[c]` is high.
- R6: Writing address 1 with bit 24 set copies the selected counter's value, as it stands before that edge, into the snapshot register. Addresses 5 and 6 then return its low and high 32 bits, and these stay fixed while the counter keeps running.
- R7: Writes to address 3 and address 4 load the low and high 32 bits of the selected count as two separate accesses, and such a write wins over an increment on the same edge. The count is 32+16·SZ_STEP bits wide and wraps to 0 from all ones. Address 4 reads the bits above 31, padded with zeros.
- R8: A counter's pending bit (address 10, bit n) becomes set one edge after its count equals its threshold (addresses 7 and 8) while its enable bit (address 9, bit n) is set. The pending bit then stays set until it is acknowledged.
- R9: Writing 1 to bit n of address 10 clears both pending bit n and enable bit n. Writing all ones clears every pending bit.
- R10: `irq` is high exactly when some counter has both its pending bit and its enable bit set. Clearing the enable bit lowers `irq` without clearing the pending bit.
- R11: Address 11 reads NUM_CTR in bits [7:0], SZ_STEP in bits [11:8] and 1 in bit 12 (interrupts present). All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| evt_in | input | NUM_COND | Event condition lines, one per condition number |
| irq | output | 1 | Level interrupt, OR of pending-and-enabled counters |

## Verification
A wrong selector decode shows up as a count or threshold that lands in a neighbouring counter, and it becomes visible on the very next read of either counter. A faulty increment path or a condition-0 leak gives a count that is off after a known number of event cycles. A stale or late snapshot capture gives snapshot halves that differ from the value preloaded just before the command. A missing automatic disable on acknowledge shows within one cycle: with the count parked on its threshold, the pending flag would set again, and address 10 or `irq` would show it at the following read.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [3:0] {
    A_SEL  = 4'd0,
    A_CTL  = 4'd1,
    A_COND = 4'd2,
    A_CNTL = 4'd3,
    A_CNTH = 4'd4,
    A_SNPL = 4'd5,
    A_SNPH = 4'd6,
    A_THRL = 4'd7,
    A_THRH = 4'd8,
    A_IEN  = 4'd9,
    A_IACT = 4'd10,
    A_BLD  = 4'd11
  } reg_addr_e;

  localparam int SNAP_BIT = 24;
endpackage

// File: rtl/evc_slice.sv
module evc_slice #(
  parameter int CW       = 48,
  parameter int NUM_COND = 16,
  parameter int CONDW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [NUM_COND-1:0] evt_in,
  input  logic                we_cond,
  input  logic                we_clo,
  input  logic                we_chi,
  input  logic                we_tlo,
  input  logic                we_thi,
  input  logic [31:0]         wdata,
  output logic [CW-1:0]       cnt,
  output logic [CW-1:0]       thr,
  output logic [CONDW-1:0]    cond,
  output logic                hit
);
  logic [63:0] cnt_nx, thr_nx;
  logic        counting;

  always_comb begin
    cnt_nx = 64'(cnt);
    if (we_clo) cnt_nx[31:0]  = wdata;
    if (we_chi) cnt_nx[63:32] = wdata;
    thr_nx = 64'(thr);
    if (we_tlo) thr_nx[31:0]  = wdata;
    if (we_thi) thr_nx[63:32] = wdata;
  end

  assign counting = run && (cond != '0) && evt_in[cond];
  assign hit      = (cnt == thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      thr  <= '0;
      cond <= '0;
    end else begin
      if (we_clo || we_chi) cnt <= cnt_nx[CW-1:0];
      else if (counting)    cnt <= cnt + 1'b1;
      if (we_tlo || we_thi) thr <= thr_nx[CW-1:0];
      if (we_cond)          cond <= wdata[CONDW-1:0];
    end
  end

  // R4: condition 0 freezes the count unless software writes it
  a_r4_never_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == '0 && !we_clo && !we_chi) |=> $stable(cnt));

  // R5: one step per qualifying edge
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cond != '0 && evt_in[cond] && !we_clo && !we_chi)
      |=> cnt == CW'($past(cnt) + 1'b1));

  // R3: run low holds the count
  a_r3_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !we_clo && !we_chi) |=> $stable(cnt));
endmodule

// File: rtl/evc_irq.sv
module evc_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         ien_we,
  input  logic         act_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] ien,
  output logic [N-1:0] act,
  output logic         irq
);
  logic [N-1:0] ack;

  assign ack = act_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= '0;
      act <= '0;
    end else begin
      if (ien_we)      ien <= wdata;
      else if (act_we) ien <= ien & ~wdata;
      act <= (act | (hit & ien)) & ~ack;
    end
  end

  assign irq = |(act & ien);

  // R9: an acknowledge clears the pending bit and its enable
  a_r9_ack_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    act_we |=> ((act & $past(wdata)) == '0) && ((ien & $past(wdata)) == '0));

  // R8: an enabled match is latched unless acknowledged
  a_r8_match_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !act_we |=> (($past(hit & ien) & ~act) == '0));

  // R8: pending bits only rise from an enabled match
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((act & ~$past(act) & ~$past(hit & ien)) == '0));
endmodule

// File: rtl/evc_bank.sv
module evc_bank #(
  parameter int NUM_CTR  = 4,
  parameter int SZ_STEP  = 1,
  parameter int NUM_COND = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [3:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_COND-1:0] evt_in,
  output logic                irq
);
  import evc_pkg::*;

  // NUM_CTR and NUM_COND are powers of two; SZ_STEP is 0 or 1.
  localparam int CW    = 32 + 16 * SZ_STEP;
  localparam int IW    = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
  localparam int CONDW = (NUM_COND > 1) ? $clog2(NUM_COND) : 1;

  logic [IW-1:0]    sel;
  logic             run;
  logic [CW-1:0]    snap;
  logic [CW-1:0]    cnt_a  [NUM_CTR];
  logic [CW-1:0]    thr_a  [NUM_CTR];
  logic [CONDW-1:0] cond_a [NUM_CTR];
  logic [NUM_CTR-1:0] hit, ien, act;
  logic             wr_ctl, snap_cmd;

  assign wr_ctl   = reg_we && (reg_addr == A_CTL);
  assign snap_cmd = wr_ctl && reg_wdata[SNAP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= '0;
      run  <= 1'b0;
      snap <= '0;
    end else begin
      if (reg_we && reg_addr == A_SEL) sel <= reg_wdata[IW-1:0];
      if (wr_ctl)                      run <= reg_wdata[0];
      if (snap_cmd)                    snap <= cnt_a[sel];
    end
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic mine;
    assign mine = reg_we && (sel == IW'(i));
    evc_slice #(.CW(CW), .NUM_COND(NUM_COND), .CONDW(CONDW)) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .evt_in  (evt_in),
      .we_cond (mine && reg_addr == A_COND),
      .we_clo  (mine && reg_addr == A_CNTL),
      .we_chi  (mine && reg_addr == A_CNTH),
      .we_tlo  (mine && reg_addr == A_THRL),
      .we_thi  (mine && reg_addr == A_THRH),
      .wdata   (reg_wdata),
      .cnt     (cnt_a[i]),
      .thr     (thr_a[i]),
      .cond    (cond_a[i]),
      .hit     (hit[i])
    );
  end

  evc_irq #(.N(NUM_CTR)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .ien_we (reg_we && reg_addr == A_IEN),
    .act_we (reg_we && reg_addr == A_IACT),
    .wdata  (reg_wdata[NUM_CTR-1:0]),
    .ien    (ien),
    .act    (act),
    .irq    (irq)
  );

  logic [63:0] cnt_w, thr_w, snp_w;
  assign cnt_w = 64'(cnt_a[sel]);
  assign thr_w = 64'(thr_a[sel]);
  assign snp_w = 64'(snap);

  always_comb begin
    case (reg_addr)
      A_SEL:   reg_rdata = 32'(sel);
      A_CTL:   reg_rdata = {31'd0, run};
      A_COND:  reg_rdata = 32'(cond_a[sel]);
      A_CNTL:  reg_rdata = cnt_w[31:0];
      A_CNTH:  reg_rdata = cnt_w[63:32];
      A_SNPL:  reg_rdata = snp_w[31:0];
      A_SNPH:  reg_rdata = snp_w[63:32];
      A_THRL:  reg_rdata = thr_w[31:0];
      A_THRH:  reg_rdata = thr_w[63:32];
      A_IEN:   reg_rdata = 32'(ien);
      A_IACT:  reg_rdata = 32'(act);
      A_BLD:   reg_rdata = {19'd0, 1'b1, 4'(SZ_STEP), 8'(NUM_CTR)};
      default: reg_rdata = 32'd0;
    endcase
  end

  // R6: a snapshot captures the selected count as it stood before the edge
  a_r6_snap_capture: assert property (@(posedge clk) disable iff (!rst_n)
    snap_cmd |=> snap == $past(cnt_a[sel]));

  // R6: the snapshot is held between commands
  a_r6_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_cmd |=> $stable(snap));

  // R3: the run bit follows bit 0 of a control write
  a_r3_run_update: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> run == $past(reg_wdata[0]));
endmodule

// File: tb/sim_evc_bank.sv
module sim_evc_bank;
  localparam int NC = 4;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NE-1:0] evt_in = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  evc_bank #(.NUM_CTR(NC), .SZ_STEP(1), .NUM_COND(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq)
  );

  // stimulus table: counter, condition, event mask, cycles, run, expected count
  localparam int NV = 6;
  localparam int T_IDX [NV] = '{0, 1, 2, 3, 0, 1};
  localparam int T_CND [NV] = '{3, 3, 0, 15, 7, 9};
  localparam int T_MSK [NV] = '{32'h0008, 32'h0010, 32'h0000FFFF, 32'h8000, 32'h0080, 32'h0200};
  localparam int T_N   [NV] = '{5, 7, 6, 9, 4, 12};
  localparam int T_RUN [NV] = '{1, 1, 1, 1, 0, 1};
  localparam int T_EXP [NV] = '{5, 0, 0, 9, 0, 12};

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rchk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R11 build word
    rchk("R1 run", 4'd1, 32'h0);
    rchk("R1 count", 4'd3, 32'h0);
    rchk("R1 thr", 4'd7, 32'h0);
    rchk("R1 ien", 4'd9, 32'h0);
    rchk("R1 iact", 4'd10, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rchk("R11 build", 4'd11, 32'h0000_1104);

    // table walk: R2 R3 R4 R5
    for (int k = 0; k < NV; k++) begin
      wr(4'd0, 32'(T_IDX[k]));
      wr(4'd1, 32'(T_RUN[k]));
      wr(4'd3, 32'h0);
      wr(4'd4, 32'h0);
      wr(4'd2, 32'(T_CND[k]));
      @(negedge clk);
      evt_in = NE'(T_MSK[k]);
      repeat (T_N[k]) @(negedge clk);
      evt_in = '0;
      wr(4'd1, 32'h0);
      rchk("R5 R4 R3 table count", 4'd3, 32'(T_EXP[k]));
      rchk("R5 table high", 4'd4, 32'h0);
    end

    // R2: counter 3 untouched by later table rows
    wr(4'd0, 32'd3);
    rchk("R2 other counter kept", 4'd3, 32'd9);
    rchk("R2 condition readback", 4'd2, 32'd15);

    // R7 wrap from all ones, split preload
    wr(4'd0, 32'd1);
    wr(4'd2, 32'd2);
    wr(4'd3, 32'hFFFF_FFFF);
    wr(4'd4, 32'h0000_FFFF);
    rchk("R7 preload high", 4'd4, 32'h0000_FFFF);
    wr(4'd1, 32'h1);
    @(negedge clk);
    evt_in = NE'(32'h4);
    @(negedge clk);
    evt_in = '0;
    wr(4'd1, 32'h0);
    rchk("R7 wrap low", 4'd3, 32'h0);
    rchk("R7 wrap high", 4'd4, 32'h0);

    // R6 snapshot while running
    wr(4'd0, 32'd2);
    wr(4'd2, 32'd5);
    wr(4'd3, 32'hFFFF_FFFE);
    wr(4'd4, 32'h1);
    @(negedge clk);
    evt_in = NE'(32'h20);
    wr(4'd1, 32'h0100_0001);
    repeat (3) @(negedge clk);
    evt_in = '0;
    wr(4'd1, 32'h0);
    rchk("R6 snap low", 4'd5, 32'hFFFF_FFFE);
    rchk("R6 snap high", 4'd6, 32'h1);
    rchk("R6 counter moved on", 4'd4, 32'h2);

    // R8 R9 R10 interrupt flow on counter 3
    wr(4'd0, 32'd3);
    wr(4'd3, 32'h0);
    wr(4'd4, 32'h0);
    wr(4'd7, 32'd4);
    wr(4'd8, 32'h0);
    wr(4'd2, 32'd1);
    wr(4'd9, 32'h8);
    rchk("R8 no early flag", 4'd10, 32'h0);
    wr(4'd1, 32'h1);
    @(negedge clk);
    evt_in = NE'(32'h2);
    repeat (4) @(negedge clk);
    evt_in = '0;
    wr(4'd1, 32'h0);
    rchk("R8 flag at threshold", 4'd10, 32'h8);
    chk("R10 irq high", 32'(irq), 32'h1);
    wr(4'd9, 32'h0);
    chk("R10 irq masked", 32'(irq), 32'h0);
    rchk("R10 flag kept", 4'd10, 32'h8);
    wr(4'd9, 32'h8);
    chk("R10 irq again", 32'(irq), 32'h1);
    wr(4'd10, 32'h8);
    rchk("R9 flag cleared", 4'd10, 32'h0);
    rchk("R9 enable cleared", 4'd9, 32'h0);
    chk("R9 irq low", 32'(irq), 32'h0);
    repeat (3) @(negedge clk);
    rchk("R9 no re-raise", 4'd10, 32'h0);
    wr(4'd9, 32'h8);
    rchk("R8 re-armed match", 4'd10, 32'h8);
    wr(4'd10, 32'hFFFF_FFFF);
    rchk("R9 all ones", 4'd10, 32'h0);
    chk("R9 irq after all ones", 32'(irq), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule